// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This block collects the interrupt sources of a ten-channel DMA controller into one 32-bit status and mask word and drives a single interrupt line. Each channel engine sends a one-cycle completion pulse. Three controller-wide events also arrive as pulses: a stall, an empty memory FIFO and a bus error. Each pulse sets a sticky status bit, and that bit stays set until software clears it.

Software reads the whole word and writes it back through a simple 32-bit write port. A 1 written into a status position clears that status bit. A 1 written into a mask position inverts that mask bit. A 0 leaves either kind of bit as it is. Because of this, one word can acknowledge events and adjust masks in a single store without a read-modify-write. The interrupt line is high whenever an enabled source is pending. The bus error is always enabled.

Top module: `dmairq_ctrl`

## Requirements
- R1: After reset every status and mask bit is 0, so `rd_data` reads 0 and `irq` is low.
- R2: A pulse on `chan_evt[n]` sets status bit n of `rd_data` (bits 9:0, channel n at bit n) on the next clock edge.
- R3: A pulse on `stall_evt` sets bit 13, a pulse on `fifo_empty_evt` sets bit 14 and a pulse on `bus_err_evt` sets bit 15.
- R4: A write with a 1 in any of bits 9:0 or 15:13 clears that status bit. A 0 in those positions leaves the bit unchanged.
- R5: A write with a 1 in any of bits 25:16 (channel n mask at bit 16+n), bit 29 (stall mask) or bit 30 (FIFO-empty mask) inverts that mask bit. A 0 leaves it unchanged. Mask bits change only on writes.
- R6: When an event pulse and a write that clears the same status bit occur in the same cycle, the bit ends up set.
- R7: `irq` is high exactly when some channel status bit n and mask bit 16+n are both 1, or bits 13 and 29 are both 1, or bits 14 and 30 are both 1, or bit 15 is 1.
- R8: Bits 12:10, 28:26 and 31 always read 0, and writing 1s to them changes no other bit and does not change `irq`.
- R9: A status bit stays set after its pulse ends until a write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `wr_data`, one cycle per write |
| wr_data | input | 32 | Write word: 1s clear status bits and invert mask bits |
| chan_evt | input | 10 | Per-channel completion pulses |
| stall_evt | input | 1 | Stall event pulse |
| fifo_empty_evt | input | 1 | Memory-FIFO-empty event pulse |
| bus_err_evt | input | 1 | Bus error event pulse |
| rd_data | output | 32 | Current status and mask word |
| irq | output | 1 | Interrupt request |

## Verification
Every state bit of the unit appears directly in `rd_data`. A wrong set, clear or toggle therefore shows up on the read word in the cycle right after the offending edge. The bench compares the whole word, not single bits, so a disturbed neighbour is caught as well. A fault in the interrupt combination is seen on `irq` in the same cycle as the state that should drive it. The bench sets up mask and status patterns in which exactly one term decides the line.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
    // Bit positions decoded by software; fixed by the register layout.
    localparam int CH_ST_LSB   = 0;
    localparam int STALL_ST    = 13;
    localparam int FEMPTY_ST   = 14;
    localparam int BUSERR_ST   = 15;
    localparam int CH_MK_LSB   = 16;
    localparam int STALL_MK    = 29;
    localparam int FEMPTY_MK   = 30;
    localparam int WORD_W      = 32;
    localparam int GLOB_ST_N   = 3;   // stall, fifo empty, bus error
    localparam int GLOB_MK_N   = 2;   // stall, fifo empty

    typedef struct packed {
        logic buserr;
        logic fempty;
        logic stall;
    } glob_evt_t;
endpackage

// File: rtl/dmairq_status_bank.sv
module dmairq_status_bank #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] bits_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_en_i ? clr_i : '0;
        st_d = st_q;
        // Clear first, then set: a same-cycle event wins.
        st_d.bits = (st_q.bits & ~clr_eff) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_o = st_q.bits;
endmodule

// File: rtl/dmairq_mask_bank.sv
module dmairq_mask_bank #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tgl_en_i,
    input  logic [W-1:0] tgl_i,
    output logic [W-1:0] bits_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } mk_t;

    mk_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (tgl_en_i) mk_d.bits = mk_q.bits ^ tgl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q <= '0;
        else        mk_q <= mk_d;
    end

    assign bits_o = mk_q.bits;
endmodule

// File: rtl/dmairq_combine.sv
module dmairq_combine
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 10
) (
    input  logic [NUM_CH-1:0]    ch_st_i,
    input  logic [NUM_CH-1:0]    ch_mk_i,
    input  glob_evt_t            glob_st_i,
    input  logic [GLOB_MK_N-1:0] glob_mk_i,  // [0] stall, [1] fifo empty
    output logic                 irq_o
);
    logic [NUM_CH-1:0] ch_hit;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign ch_hit[n] = ch_st_i[n] & ch_mk_i[n];
    end

    always_comb begin
        irq_o = (|ch_hit)
              | (glob_st_i.stall  & glob_mk_i[0])
              | (glob_st_i.fempty & glob_mk_i[1])
              | glob_st_i.buserr;
    end
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [NUM_CH-1:0] chan_evt,
    input  logic              stall_evt,
    input  logic              fifo_empty_evt,
    input  logic              bus_err_evt,
    output logic [31:0]       rd_data,
    output logic              irq
);
    localparam int ST_W = NUM_CH + GLOB_ST_N;
    localparam int MK_W = NUM_CH + GLOB_MK_N;

    logic [ST_W-1:0] st_set, st_clr, st_bits;
    logic [MK_W-1:0] mk_tgl, mk_bits;
    glob_evt_t       glob_st;
    logic [31:0]     used_mask;
    logic            unused_wr_bits;

    always_comb begin
        st_set = {bus_err_evt, fifo_empty_evt, stall_evt, chan_evt};
        st_clr = {wr_data[BUSERR_ST], wr_data[FEMPTY_ST], wr_data[STALL_ST],
                  wr_data[CH_ST_LSB +: NUM_CH]};
        mk_tgl = {wr_data[FEMPTY_MK], wr_data[STALL_MK],
                  wr_data[CH_MK_LSB +: NUM_CH]};
    end

    dmairq_status_bank #(.W(ST_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (st_set),
        .clr_en_i (wr_en),
        .clr_i    (st_clr),
        .bits_o   (st_bits)
    );

    dmairq_mask_bank #(.W(MK_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgl_en_i (wr_en),
        .tgl_i    (mk_tgl),
        .bits_o   (mk_bits)
    );

    assign glob_st = glob_evt_t'(st_bits[ST_W-1 -: GLOB_ST_N]);

    dmairq_combine #(.NUM_CH(NUM_CH)) u_comb (
        .ch_st_i   (st_bits[NUM_CH-1:0]),
        .ch_mk_i   (mk_bits[NUM_CH-1:0]),
        .glob_st_i (glob_st),
        .glob_mk_i (mk_bits[MK_W-1 -: GLOB_MK_N]),
        .irq_o     (irq)
    );

    always_comb begin
        rd_data = '0;
        rd_data[CH_ST_LSB +: NUM_CH] = st_bits[NUM_CH-1:0];
        rd_data[STALL_ST]            = glob_st.stall;
        rd_data[FEMPTY_ST]           = glob_st.fempty;
        rd_data[BUSERR_ST]           = glob_st.buserr;
        rd_data[CH_MK_LSB +: NUM_CH] = mk_bits[NUM_CH-1:0];
        rd_data[STALL_MK]            = mk_bits[NUM_CH];
        rd_data[FEMPTY_MK]           = mk_bits[NUM_CH+1];
    end

    // Bits of the write word with no storage behind them.
    always_comb begin
        used_mask = '0;
        used_mask[CH_ST_LSB +: NUM_CH] = '1;
        used_mask[CH_MK_LSB +: NUM_CH] = '1;
        used_mask[STALL_ST]  = 1'b1;
        used_mask[FEMPTY_ST] = 1'b1;
        used_mask[BUSERR_ST] = 1'b1;
        used_mask[STALL_MK]  = 1'b1;
        used_mask[FEMPTY_MK] = 1'b1;
        unused_wr_bits = ^(wr_data & ~used_mask);
    end
endmodule

// File: rtl/dmairq_ctrl_chk.sv
module dmairq_ctrl_chk #(
    parameter int NUM_CH = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic [NUM_CH-1:0] chan_evt,
    input logic              stall_evt,
    input logic              fifo_empty_evt,
    input logic              bus_err_evt,
    input logic [31:0]       rd_data,
    input logic              irq
);
    localparam logic [31:0] CH_BITS = (32'd1 << NUM_CH) - 32'd1;
    localparam logic [31:0] USED    = CH_BITS | (CH_BITS << 16) | 32'h6000_E000;

    // R2: a channel pulse is visible in the status field one edge later
    p_chan_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_evt) |=> ((rd_data[NUM_CH-1:0] & $past(chan_evt)) == $past(chan_evt)));

    // R3: global pulses set their bits
    p_glob_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_evt || fifo_empty_evt || bus_err_evt) |=>
        ((rd_data[15:13] & $past({bus_err_evt, fifo_empty_evt, stall_evt}))
          == $past({bus_err_evt, fifo_empty_evt, stall_evt})));

    // R4: written 1s clear channel status absent a new event
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_data[NUM_CH-1:0] & $past(wr_data[NUM_CH-1:0]) & ~$past(chan_evt)) == '0));

    // R5: masks invert on written 1s
    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[16 +: NUM_CH] == ($past(rd_data[16 +: NUM_CH]) ^ $past(wr_data[16 +: NUM_CH]))));

    // R5: masks hold without a write
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rd_data[16 +: NUM_CH]) && $stable(rd_data[30:29])));

    // R6: event beats clear on the same bit
    p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_data[NUM_CH-1:0] & chan_evt) != '0)) |=>
        ((rd_data[NUM_CH-1:0] & $past(wr_data[NUM_CH-1:0] & chan_evt))
          == $past(wr_data[NUM_CH-1:0] & chan_evt)));

    // R7: an unmasked bus error always raises the line
    p_buserr_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15] |-> irq);

    // R8: reserved bits read 0
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~USED) == 32'd0);

    // R9: status bits are sticky without a write
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rd_data[15:0] & $past(rd_data[15:0])) == $past(rd_data[15:0])));
endmodule

bind dmairq_ctrl dmairq_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .chan_evt       (chan_evt),
    .stall_evt      (stall_evt),
    .fifo_empty_evt (fifo_empty_evt),
    .bus_err_evt    (bus_err_evt),
    .rd_data        (rd_data),
    .irq            (irq)
);

// File: tb/dmairq_ctrl_tb_top.sv
module dmairq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [9:0]  chan_evt = '0;
    logic        stall_evt = 1'b0;
    logic        fifo_empty_evt = 1'b0;
    logic        bus_err_evt = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_w = '0;   // bench model of the register word

    always #5 clk = ~clk;

    dmairq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .chan_evt(chan_evt), .stall_evt(stall_evt),
        .fifo_empty_evt(fifo_empty_evt), .bus_err_evt(bus_err_evt),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic logic model_irq(input logic [31:0] w);
        return (|(w[9:0] & w[25:16])) | (w[13] & w[29]) | (w[14] & w[30]) | w[15];
    endfunction

    task automatic check(input string req);
        checks++;
        if (rd_data !== exp_w) begin
            errors++;
            $display("FAIL %s rd_data actual %h expected %h", req, rd_data, exp_w);
        end
        checks++;
        if (irq !== model_irq(exp_w)) begin
            errors++;
            $display("FAIL %s irq actual %b expected %b", req, irq, model_irq(exp_w));
        end
    endtask

    // One cycle of stimulus; model updated per R4, R5, R6, R2, R3.
    task automatic cycle(input logic we, input logic [31:0] wd, input logic [9:0] ce,
                         input logic st, input logic fe, input logic be);
        logic [31:0] evt;
        @(negedge clk);
        wr_en = we; wr_data = wd; chan_evt = ce;
        stall_evt = st; fifo_empty_evt = fe; bus_err_evt = be;
        evt = {16'd0, be, fe, st, 3'd0, ce};
        if (we) begin
            exp_w = exp_w & ~(wd & 32'h0000_E3FF);
            exp_w = exp_w ^ (wd & 32'h63FF_0000);
        end
        exp_w = exp_w | evt;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; chan_evt = '0;
        stall_evt = 1'b0; fifo_empty_evt = 1'b0; bus_err_evt = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        exp_w = '0;
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");
    endtask

    task automatic t_chan_events();
        for (int n = 0; n < 10; n++) begin
            cycle(1'b0, '0, 10'd1 << n, 1'b0, 1'b0, 1'b0);
            check("R2");
        end
        cycle(1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        check("R9");
    endtask

    task automatic t_glob_events();
        cycle(1'b0, '0, '0, 1'b1, 1'b0, 1'b0); check("R3");
        cycle(1'b0, '0, '0, 1'b0, 1'b1, 1'b0); check("R3");
        cycle(1'b0, '0, '0, 1'b0, 1'b0, 1'b1); check("R3");
    endtask

    task automatic t_clear();
        cycle(1'b1, 32'h0000_0155, '0, 1'b0, 1'b0, 1'b0); check("R4");
        cycle(1'b1, 32'h0000_A000, '0, 1'b0, 1'b0, 1'b0); check("R4");
        cycle(1'b1, 32'h0000_0000, '0, 1'b0, 1'b0, 1'b0); check("R4");
        cycle(1'b1, 32'h0000_E3FF, '0, 1'b0, 1'b0, 1'b0); check("R4");
    endtask

    task automatic t_toggle();
        cycle(1'b1, 32'h0155_0000, '0, 1'b0, 1'b0, 1'b0); check("R5");
        cycle(1'b1, 32'h6003_0000, '0, 1'b0, 1'b0, 1'b0); check("R5");
        cycle(1'b1, 32'h0155_0000, '0, 1'b0, 1'b0, 1'b0); check("R5");
        cycle(1'b0, 32'hFFFF_FFFF, '0, 1'b0, 1'b0, 1'b0); check("R5");
        cycle(1'b1, 32'h6003_0000, '0, 1'b0, 1'b0, 1'b0); check("R5");
    endtask

    task automatic t_collision();
        cycle(1'b0, '0, 10'h210, 1'b1, 1'b0, 1'b0); check("R6");
        cycle(1'b1, 32'h0000_2210, 10'h200, 1'b1, 1'b0, 1'b0); check("R6");
        cycle(1'b1, 32'h0000_E3FF, '0, 1'b0, 1'b0, 1'b0); check("R6");
    endtask

    task automatic t_irq();
        cycle(1'b1, 32'h0008_0000, '0, 1'b0, 1'b0, 1'b0); check("R7");        // mask ch3
        cycle(1'b0, '0, 10'h020, 1'b0, 1'b0, 1'b0); check("R7");             // ch5 unmasked: low
        cycle(1'b0, '0, 10'h008, 1'b0, 1'b0, 1'b0); check("R7");             // ch3: high
        cycle(1'b1, 32'h0000_0008, '0, 1'b0, 1'b0, 1'b0); check("R7");       // clear ch3: low
        cycle(1'b0, '0, '0, 1'b1, 1'b1, 1'b0); check("R7");                  // globals, no mask
        cycle(1'b1, 32'h4000_0000, '0, 1'b0, 1'b0, 1'b0); check("R7");       // fifo mask on
        cycle(1'b1, 32'h6000_4000, '0, 1'b0, 1'b0, 1'b0); check("R7");       // stall only
        cycle(1'b1, 32'h2000_2020, '0, 1'b0, 1'b0, 1'b0); check("R7");       // all off
        cycle(1'b0, '0, '0, 1'b0, 1'b0, 1'b1); check("R7");                  // bus error
        cycle(1'b1, 32'h0008_8000, '0, 1'b0, 1'b0, 1'b0); check("R7");
    endtask

    task automatic t_unused();
        cycle(1'b1, 32'h9C00_1C00, '0, 1'b0, 1'b0, 1'b0); check("R8");
        cycle(1'b0, '0, 10'h001, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 32'h1000_0000, '0, 1'b0, 1'b0, 1'b0); check("R8");
    endtask

    initial begin
        t_reset();
        t_chan_events();
        t_glob_events();
        t_clear();
        t_toggle();
        t_collision();
        t_irq();
        t_unused();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule